// File: doc/BRIEF.md
# Prioritized Multi-Source Interrupt Controller

This block collects a parameterised number of external interrupt lines and presents them to one processor as a single request line, `irq_o`, plus a small synchronous register port. Software programs each source through its own configuration word: vector, 4-bit priority, edge or level sensing, polarity, and a mask. A separate routing word per source decides whether the source may reach this processor. The processor claims an interrupt by reading the acknowledge address. The read returns the winning vector and places the source in service. A later write to the end-of-interrupt address retires it.

Delivery is filtered by two things: a task-priority threshold held in a register, and the priority of the interrupt currently in service. Only strictly higher priorities get through, so acknowledges nest and each end-of-interrupt retires the most recently acknowledged source. A global self-clearing reset bit returns every source to the masked default. A read-only word reports the number of sources and processors.

Register map (8-bit word address, 32-bit data). Feature at 0x00. Configuration at 0x01. Spurious vector at 0x02. Task priority at 0x03. Acknowledge at 0x04. End-of-interrupt at 0x05. Source i has its configuration word at 0x40+2i and its routing word at 0x41+2i. Read data appears on `rd_data_o` in the cycle after `rd_en_i` is sampled.

Top module: `irqc_top`

## Requirements
- R1: After reset every source word reads 0x8000_0000 (masked, all else zero), every routing word reads 0, the task priority reads 15, the spurious vector reads 0xFF, the configuration word reads 0, and `irq_o` is low.
- R2: The feature word reads {NUM_SRC-1} in bits [15:8] and {NUM_CPU-1} in bits [7:0], with all other bits zero.
- R3: The source word holds the vector in bits [7:0], priority in [19:16], sense in bit 22 (0 edge, 1 level), polarity in bit 23 (0 low/falling, 1 high/rising), activity in bit 30 and mask in bit 31. Activity is read-only: a write to bit 30 does not change it.
- R4: An edge source becomes pending on the selected edge only and stays pending after the input returns. It latches the edge even while masked. Activity (bit 30) reads 1 while it is pending.
- R5: A level source is pending exactly while its input sits at the selected level. It is not latched.
- R6: A source is delivered only if its priority is strictly greater than the task priority. Task priority 15 blocks everything, and priority 0 is never delivered.
- R7: An acknowledge read returns the vector of the highest-priority deliverable source, with ties going to the lowest index. A source needs mask=0 and bit 0 of its routing word set to be deliverable.
- R8: An acknowledge read with no deliverable source returns the spurious vector and changes no state.
- R9: An acknowledged source stays in service with activity 1 until retired, even if masked or its input drops. An edge source's pending latch is cleared by the acknowledge.
- R10: While a source is in service, only strictly higher priorities are delivered. A write to the end-of-interrupt address retires the most recently acknowledged (highest-priority) in-service source.
- R11: An end-of-interrupt write while nothing is in service has no effect.
- R12: Writing 1 to bit 0 of the configuration word starts an internal reset. Bit 0 reads 1 for RST_CYC cycles and then clears itself. Afterwards all source words read masked with other fields zero, routing words are zero, and all pending and in-service state is cleared.
- R13: `irq_o` is high exactly when an acknowledge read would return a source vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register word address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe (acknowledge has side effects) |
| rd_data_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| irq_src_i | input | NUM_SRC | External interrupt lines |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The threshold rule is swept over every pair of task priority and source priority on a single level source. This separates a strict comparison from a non-strict one and shows that priority 0 is blocked. A second sweep assigns each of four sources every combination of priorities from {0, 3, 7} with all lines active. It checks the arbitration winner against an arithmetic model, which exposes wrong tie-breaking or a wrong priority order, and a follow-up acknowledge shows that nesting suppresses equal or lower priorities. Directed sequences then cover both edge polarities, active-low level sensing, latching while masked, routing, nested end-of-interrupt order, an end-of-interrupt with nothing in service, and the self-clearing reset window.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned PRI_W  = 4;
  localparam int unsigned VEC_W  = 8;

  // source word field positions
  localparam int unsigned F_VEC_LSB = 0;
  localparam int unsigned F_PRI_LSB = 16;
  localparam int unsigned F_SENSE   = 22;
  localparam int unsigned F_POL     = 23;
  localparam int unsigned F_ACT     = 30;
  localparam int unsigned F_MASK    = 31;

  localparam logic [ADDR_W-1:0] A_FEATURE  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CONFIG   = 8'h01;
  localparam logic [ADDR_W-1:0] A_SPUR     = 8'h02;
  localparam logic [ADDR_W-1:0] A_TASKPRI  = 8'h03;
  localparam logic [ADDR_W-1:0] A_ACK      = 8'h04;
  localparam logic [ADDR_W-1:0] A_EOI      = 8'h05;
  localparam logic [ADDR_W-1:0] A_SRC_BASE = 8'h40;

  localparam logic [PRI_W-1:0] PRI_BLOCK_ALL = 4'hf;
  localparam logic [VEC_W-1:0] SPUR_RST      = 8'hff;
endpackage

// File: rtl/irqc_src.sv
module irqc_src
  import irqc_pkg::*;
#(
  parameter int unsigned DEST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              irq_i,
  input  logic              vp_we_i,
  input  logic              dest_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic [WORD_W-1:0] vp_o,
  output logic [WORD_W-1:0] dest_o,
  output logic [PRI_W-1:0]  pri_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              req_o,
  output logic              in_svc_o,
  output logic              mask_o
);
  logic [VEC_W-1:0]  vec_q;
  logic [PRI_W-1:0]  pri_q;
  logic              sense_q, pol_q, mask_q, edge_q, svc_q, prev_q;
  logic [DEST_W-1:0] dest_q;
  logic              active, act_prev, edge_evt, pend;

  assign active   = pol_q ? irq_i  : ~irq_i;
  assign act_prev = pol_q ? prev_q : ~prev_q;
  assign edge_evt = active & ~act_prev;
  assign pend     = sense_q ? active : edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0; pri_q <= '0; sense_q <= 1'b0; pol_q <= 1'b0;
      mask_q <= 1'b1; dest_q <= '0; edge_q <= 1'b0; svc_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= irq_i;
      if (clr_i) begin
        vec_q <= '0; pri_q <= '0; sense_q <= 1'b0; pol_q <= 1'b0;
        mask_q <= 1'b1; dest_q <= '0; edge_q <= 1'b0; svc_q <= 1'b0;
      end else begin
        if (vp_we_i) begin
          vec_q   <= wdata_i[F_VEC_LSB +: VEC_W];
          pri_q   <= wdata_i[F_PRI_LSB +: PRI_W];
          sense_q <= wdata_i[F_SENSE];
          pol_q   <= wdata_i[F_POL];
          mask_q  <= wdata_i[F_MASK];
        end
        if (dest_we_i) dest_q <= wdata_i[DEST_W-1:0];
        // a new edge in the ack cycle stays latched
        edge_q <= ~sense_q & (edge_evt | (edge_q & ~ack_i));
        if (ack_i)      svc_q <= 1'b1;
        else if (eoi_i) svc_q <= 1'b0;
      end
    end
  end

  always_comb begin
    vp_o                       = '0;
    vp_o[F_VEC_LSB +: VEC_W]   = vec_q;
    vp_o[F_PRI_LSB +: PRI_W]   = pri_q;
    vp_o[F_SENSE]              = sense_q;
    vp_o[F_POL]                = pol_q;
    vp_o[F_ACT]                = pend | svc_q;
    vp_o[F_MASK]               = mask_q;
    dest_o                     = '0;
    dest_o[DEST_W-1:0]         = dest_q;
  end

  assign pri_o    = pri_q;
  assign vec_o    = vec_q;
  assign req_o    = pend & ~mask_q & dest_q[0] & ~svc_q;
  assign in_svc_o = svc_q;
  assign mask_o   = mask_q;

  // acknowledge only ever lands on a requesting source
  assert_ack_on_request_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> req_o);
  // in-service state survives until retired or cleared
  assert_svc_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_q && !eoi_i && !clr_i) |=> vp_o[F_ACT]);
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*PRI_W-1:0] pri_i,
  input  logic [PRI_W-1:0]         thr_i,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [PRI_W-1:0] best;

  // seeding with the threshold folds the strict compare into the search;
  // strict '>' keeps the lowest index on ties
  always_comb begin
    best    = thr_i;
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (pri_i[i*PRI_W +: PRI_W] > best)) begin
        best    = pri_i[i*PRI_W +: PRI_W];
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  assert_win_above_thr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (req_i[idx_o] && (pri_i[idx_o*PRI_W +: PRI_W] > thr_i)));
endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 7,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] top_ptr, wr_ptr;

  assign top_ptr = PTR_W'(cnt_q - 1'b1);
  assign wr_ptr  = pop_i ? top_ptr : PTR_W'(cnt_q);
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_o   = empty_o ? '0 : mem_q[top_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      if (push_i) mem_q[wr_ptr] <= data_i;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> !full_o);
  assert_no_underflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned RST_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         addr_i,
  input  logic               wr_en_i,
  input  logic [31:0]        wr_data_i,
  input  logic               rd_en_i,
  output logic [31:0]        rd_data_o,
  input  logic [NUM_SRC-1:0] irq_src_i,
  output logic               irq_o
);
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned ENT_W  = PRI_W + IDX_W;
  localparam int unsigned RCNT_W = $clog2(RST_CYC + 1);

  logic [PRI_W-1:0]  task_pri_q;
  logic [VEC_W-1:0]  spur_q;
  logic [RCNT_W-1:0] rst_cnt_q;
  logic [WORD_W-1:0] rd_q, rd_next;
  logic              busy;

  logic [WORD_W-1:0]        vp_w   [NUM_SRC];
  logic [WORD_W-1:0]        dest_w [NUM_SRC];
  logic [VEC_W-1:0]         vec_w  [NUM_SRC];
  logic [NUM_SRC*PRI_W-1:0] pri_flat;
  logic [NUM_SRC-1:0]       req_vec, svc_vec, mask_vec;

  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [PRI_W-1:0] win_pri, top_pri, thr;
  logic [IDX_W-1:0] top_idx;
  logic [ENT_W-1:0] stk_top;
  logic             stk_empty, stk_full;
  logic             ack_fire, eoi_fire;

  assign busy     = (rst_cnt_q != '0);
  assign ack_fire = rd_en_i && (addr_i == A_ACK) && win_valid && !busy;
  assign eoi_fire = wr_en_i && (addr_i == A_EOI) && !stk_empty && !busy;

  assign top_pri = stk_top[ENT_W-1 -: PRI_W];
  assign top_idx = stk_top[IDX_W-1:0];
  assign thr     = (!stk_empty && (top_pri > task_pri_q)) ? top_pri : task_pri_q;
  assign win_pri = pri_flat[win_idx*PRI_W +: PRI_W];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irqc_src #(.DEST_W(NUM_CPU)) i_src (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (busy),
      .irq_i     (irq_src_i[g]),
      .vp_we_i   (wr_en_i && !busy && (addr_i == ADDR_W'(A_SRC_BASE + 2*g))),
      .dest_we_i (wr_en_i && !busy && (addr_i == ADDR_W'(A_SRC_BASE + 2*g + 1))),
      .wdata_i   (wr_data_i),
      .ack_i     (ack_fire && (win_idx == IDX_W'(g))),
      .eoi_i     (eoi_fire && (top_idx == IDX_W'(g))),
      .vp_o      (vp_w[g]),
      .dest_o    (dest_w[g]),
      .pri_o     (pri_flat[g*PRI_W +: PRI_W]),
      .vec_o     (vec_w[g]),
      .req_o     (req_vec[g]),
      .in_svc_o  (svc_vec[g]),
      .mask_o    (mask_vec[g])
    );
  end

  irqc_arb #(.NUM_SRC(NUM_SRC)) i_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_vec),
    .pri_i   (pri_flat),
    .thr_i   (thr),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  irqc_stack #(.DEPTH(NUM_SRC), .W(ENT_W)) i_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (busy),
    .push_i  (ack_fire),
    .pop_i   (eoi_fire),
    .data_i  ({win_pri, win_idx}),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  always_comb begin
    rd_next = '0;
    case (addr_i)
      A_FEATURE: begin
        rd_next[15:8] = 8'(NUM_SRC - 1);
        rd_next[7:0]  = 8'(NUM_CPU - 1);
      end
      A_CONFIG:  rd_next[0] = busy;
      A_SPUR:    rd_next[VEC_W-1:0] = spur_q;
      A_TASKPRI: rd_next[PRI_W-1:0] = task_pri_q;
      A_ACK:     rd_next[VEC_W-1:0] = ack_fire ? vec_w[win_idx] : spur_q;
      default: begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (addr_i == ADDR_W'(A_SRC_BASE + 2*i))     rd_next = vp_w[i];
          if (addr_i == ADDR_W'(A_SRC_BASE + 2*i + 1)) rd_next = dest_w[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      task_pri_q <= PRI_BLOCK_ALL;
      spur_q     <= SPUR_RST;
      rst_cnt_q  <= '0;
      rd_q       <= '0;
    end else begin
      if (rd_en_i) rd_q <= rd_next;
      if (wr_en_i && (addr_i == A_TASKPRI)) task_pri_q <= wr_data_i[PRI_W-1:0];
      if (wr_en_i && (addr_i == A_SPUR))    spur_q     <= wr_data_i[VEC_W-1:0];
      if (busy) rst_cnt_q <= rst_cnt_q - 1'b1;
      else if (wr_en_i && (addr_i == A_CONFIG) && wr_data_i[0])
        rst_cnt_q <= RCNT_W'(RST_CYC);
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = win_valid && !busy;

  assert_ack_above_task_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |-> (win_pri > task_pri_q));
  assert_eoi_retires_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_fire |=> !svc_vec[$past(top_idx)]);
  assert_reset_masks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> ((&mask_vec) && (svc_vec == '0)));
  assert_stack_tracks_svc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_empty |-> (svc_vec == '0));
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NC = 2;
  localparam int RC = 3;
  localparam logic [7:0] SPUR = 8'hEE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NS-1:0] src_in = '0;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  logic [31:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top #(.NUM_SRC(NS), .NUM_CPU(NC), .RST_CYC(RC)) i_irqc_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rdata),
    .irq_src_i(src_in), .irq_o(irq)
  );

  function automatic logic [31:0] vpw(input int vec, input int pri, input bit sense,
                                      input bit pol, input bit mask);
    return 32'(vec & 8'hff) | (32'(pri & 4'hf) << 16) | (32'(sense) << 22)
         | (32'(pol) << 23) | (32'(mask) << 31);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  function automatic logic [7:0] vpa(input int i); return 8'(8'h40 + 2*i); endfunction
  function automatic logic [7:0] dsa(input int i); return 8'(8'h41 + 2*i); endfunction

  task automatic clean();
    src_in = '0;
    for (int i = 0; i < NS; i++) begin
      wr(vpa(i), vpw(0, 0, 1'b0, 1'b0, 1'b1));
      wr(dsa(i), 32'h0);
    end
    @(negedge clk);
  endtask

  task automatic pulse(input int i);
    @(negedge clk); src_in[i] = 1'b1;
    @(negedge clk); src_in[i] = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int pv [3];
    pv[0] = 0; pv[1] = 3; pv[2] = 7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 feature
    chk("R1 irq_o", {31'b0, irq}, 32'h0);
    rd(8'h00, d); chk("R2 feature", d, 32'h0000_0301);
    rd(8'h01, d); chk("R1 config", d, 32'h0);
    rd(8'h02, d); chk("R1 spurious", d, 32'hFF);
    rd(8'h03, d); chk("R1 task pri", d, 32'hF);
    for (int i = 0; i < NS; i++) begin
      rd(vpa(i), d); chk("R1 source word", d, 32'h8000_0000);
      rd(dsa(i), d); chk("R1 routing word", d, 32'h0);
    end
    wr(8'h02, {24'b0, SPUR});

    // R3 layout, activity read-only
    wr(vpa(0), 32'h4000_0000 | vpw(8'h20, 10, 1'b1, 1'b1, 1'b0));
    rd(vpa(0), d); chk("R3 layout/activity ro", d, 32'h00CA_0020);
    clean();

    // R6 sweep: task x source priority on level source 0
    wr(dsa(0), 32'h1);
    src_in[0] = 1'b1;
    for (int t = 0; t < 16; t++) begin
      for (int p = 0; p < 16; p++) begin
        wr(8'h03, 32'(t));
        wr(vpa(0), vpw(8'h20, p, 1'b1, 1'b1, 1'b0));
        chk("R6/R13 irq_o", {31'b0, irq}, {31'b0, (p > t)});
        rd(8'h04, d);
        chk("R6 threshold", d, (p > t) ? 32'h20 : {24'b0, SPUR});
        if (p > t) wr(8'h05, 32'h0);
      end
    end
    clean();

    // R7 sweep: arbitration over four level sources
    wr(8'h03, 32'h0);
    for (int i = 0; i < NS; i++) wr(dsa(i), 32'h1);
    src_in = '1;
    for (int code = 0; code < 81; code++) begin
      int c, bp, bi;
      int pr [NS];
      c = code; bp = 0; bi = -1;
      for (int i = 0; i < NS; i++) begin
        pr[i] = pv[c % 3]; c = c / 3;
        wr(vpa(i), vpw(8'h20 + i, pr[i], 1'b1, 1'b1, 1'b0));
        if (pr[i] > bp) begin bp = pr[i]; bi = i; end
      end
      rd(8'h04, d);
      chk("R7 winner", d, (bi >= 0) ? 32'(8'h20 + bi) : {24'b0, SPUR});
      if (bi >= 0) begin
        rd(8'h04, d); chk("R10 no equal/lower nest", d, {24'b0, SPUR});
        wr(8'h05, 32'h0);
      end
    end
    clean();

    // R4 rising edge
    wr(8'h03, 32'h0);
    wr(dsa(0), 32'h1);
    wr(vpa(0), vpw(8'h20, 4, 1'b0, 1'b1, 1'b0));
    rd(vpa(0), d); chk("R4 idle activity", d[30], 1'b0);
    pulse(0);
    rd(vpa(0), d); chk("R4 edge latched", d[30], 1'b1);
    rd(8'h04, d); chk("R4 edge ack", d, 32'h20);
    rd(vpa(0), d); chk("R9 in service activity", d[30], 1'b1);
    wr(8'h05, 32'h0);
    rd(vpa(0), d); chk("R9 retired activity", d[30], 1'b0);

    // R4 falling edge
    wr(dsa(1), 32'h1);
    wr(vpa(1), vpw(8'h21, 4, 1'b0, 1'b0, 1'b0));
    @(negedge clk); src_in[1] = 1'b1; @(negedge clk);
    rd(vpa(1), d); chk("R4 wrong edge ignored", d[30], 1'b0);
    src_in[1] = 1'b0; @(negedge clk);
    rd(vpa(1), d); chk("R4 falling edge latched", d[30], 1'b1);
    rd(8'h04, d); chk("R4 falling ack", d, 32'h21);
    wr(8'h05, 32'h0);

    // R4 latched while masked
    wr(vpa(0), vpw(8'h20, 4, 1'b0, 1'b1, 1'b1));
    pulse(0);
    rd(vpa(0), d); chk("R4 masked latch word", d, 32'hC084_0020);
    chk("R13 masked no irq", {31'b0, irq}, 32'h0);
    rd(8'h04, d); chk("R8 masked -> spurious", d, {24'b0, SPUR});
    wr(vpa(0), vpw(8'h20, 4, 1'b0, 1'b1, 1'b0));
    rd(8'h04, d); chk("R4 delivered after unmask", d, 32'h20);
    wr(8'h05, 32'h0);
    clean();

    // R7 routing
    wr(8'h03, 32'h0);
    wr(vpa(2), vpw(8'h22, 6, 1'b1, 1'b1, 1'b0));
    wr(dsa(2), 32'h2);
    src_in[2] = 1'b1;
    @(negedge clk);
    chk("R7 unrouted no irq", {31'b0, irq}, 32'h0);
    rd(8'h04, d); chk("R7 unrouted -> spurious", d, {24'b0, SPUR});
    wr(dsa(2), 32'h1);
    rd(dsa(2), d); chk("R7 routing readback", d, 32'h1);
    rd(8'h04, d); chk("R7 routed ack", d, 32'h22);
    wr(8'h05, 32'h0);
    clean();

    // R5 active-low level
    wr(8'h03, 32'h0);
    wr(dsa(3), 32'h1);
    src_in[3] = 1'b1;
    wr(vpa(3), vpw(8'h23, 2, 1'b1, 1'b0, 1'b0));
    rd(vpa(3), d); chk("R5 inactive level", d[30], 1'b0);
    chk("R13 no irq", {31'b0, irq}, 32'h0);
    src_in[3] = 1'b0; @(negedge clk);
    rd(vpa(3), d); chk("R5 active level", d[30], 1'b1);
    chk("R13 irq high", {31'b0, irq}, 32'h1);
    src_in[3] = 1'b1; @(negedge clk);
    rd(vpa(3), d); chk("R5 not latched", d[30], 1'b0);

    // R9 in service survives mask and input drop
    src_in[3] = 1'b0; @(negedge clk);
    rd(8'h04, d); chk("R9 ack", d, 32'h23);
    wr(vpa(3), vpw(8'h23, 2, 1'b1, 1'b0, 1'b1));
    rd(vpa(3), d); chk("R9 masked in service", d[30], 1'b1);
    src_in[3] = 1'b1; @(negedge clk);
    rd(vpa(3), d); chk("R9 input dropped in service", d[30], 1'b1);
    wr(8'h05, 32'h0);
    rd(vpa(3), d); chk("R9 retired", d[30], 1'b0);
    clean();

    // R10 nesting with edge sources
    wr(8'h03, 32'h0);
    for (int i = 0; i < 3; i++) wr(dsa(i), 32'h1);
    wr(vpa(0), vpw(8'h20, 5, 1'b0, 1'b1, 1'b0));
    wr(vpa(1), vpw(8'h21, 3, 1'b0, 1'b1, 1'b0));
    wr(vpa(2), vpw(8'h22, 9, 1'b0, 1'b1, 1'b0));
    pulse(0);
    rd(8'h04, d); chk("R10 first ack", d, 32'h20);
    pulse(1);
    chk("R10 lower blocked irq", {31'b0, irq}, 32'h0);
    rd(8'h04, d); chk("R10 lower blocked", d, {24'b0, SPUR});
    pulse(2);
    rd(8'h04, d); chk("R10 higher nests", d, 32'h22);
    wr(8'h05, 32'h0);
    rd(vpa(2), d); chk("R10 eoi retires newest", d[30], 1'b0);
    rd(vpa(0), d); chk("R10 older still in service", d[30], 1'b1);
    wr(8'h05, 32'h0);
    rd(vpa(0), d); chk("R10 second eoi", d[30], 1'b0);
    rd(8'h04, d); chk("R10 lower now delivered", d, 32'h21);
    wr(8'h05, 32'h0);

    // R11 eoi with nothing in service
    pulse(1);
    wr(8'h05, 32'h0);
    rd(vpa(1), d); chk("R11 eoi no effect", d[30], 1'b1);
    rd(8'h04, d); chk("R11 still deliverable", d, 32'h21);
    wr(8'h05, 32'h0);

    // R12 self-clearing reset
    pulse(0);
    rd(8'h04, d); chk("R12 pre ack", d, 32'h20);
    pulse(2);
    wr(8'h01, 32'h1);
    rd(8'h01, d); chk("R12 busy reads 1", d, 32'h1);
    repeat (RC + 2) @(negedge clk);
    rd(8'h01, d); chk("R12 self clears", d, 32'h0);
    for (int i = 0; i < 3; i++) begin
      rd(vpa(i), d); chk("R12 source masked", d, 32'h8000_0000);
      rd(dsa(i), d); chk("R12 routing cleared", d, 32'h0);
    end
    rd(8'h04, d); chk("R12 nothing deliverable", d, {24'b0, SPUR});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule